// File: doc/BRIEF.md
# Multi-Wavefront Issue Scheduler

This block picks, every clock cycle, which resident wavefronts of one SIMD send an instruction to each of four execution classes: vector ALU, scalar ALU, vector memory, and local/scalar memory. Each wavefront slot keeps its own program counter, its own priority, its own sleep timer and its own outstanding-access counters. Switching between wavefronts therefore moves no state. An external instruction buffer shows one head instruction per slot. The scheduler answers with a per-slot pop strobe and with one grant per class, which carries the slot number and the program counter.

Some instructions never leave the scheduler: wait, nop, sleep, barrier, set-priority, vector-skip and halt. A wait compares the slot's counters against the thresholds it encodes. If they are not met, the wait stays at the head and is checked again on the next cycle. Other slots issue freely in the meantime. Memory completions arrive as single-cycle pulses tagged with a slot id.

Top module: `wave_issue_sched`

## Requirements
- R1: After reset no slot is active, nothing is issued and no head is popped, even when heads are valid.
- R2: A launch pulse activates an idle slot with the given start PC and workgroup id, but only when the slot index is below `slot_cap`. A launch to a slot at or above the cap leaves that slot inactive.
- R3: Op codes (4 bits) map to classes as follows: 0 vector ALU → class 0, 1 scalar ALU → class 1, 2 vector memory → class 2, 3 local memory and 4 scalar load → class 3. Each class grants at most one slot per cycle, and the slots granted in one cycle are all different. A grant reports the slot and its current PC and pops that head. Every pop advances the slot PC by one.
- R4: Among requesters of equal priority, a class grants round robin. The search starts at the slot after the last one granted in that class, and starts at slot 0 after reset.
- R5: Op 9 (set priority) loads the argument's low 2 bits as the slot priority. In each class, a requester with higher priority wins over lower ones.
- R6: Op codes 5 to 15 are consumed inside the scheduler and never produce a grant.
- R7: Op 5 (wait) takes a vector-memory threshold in argument bits [3:0] and a local/scalar threshold in bits [7:4]. It is popped only in a cycle in which both counters are at or below their thresholds.
- R8: While any scalar load of the slot is outstanding, the local/scalar threshold of a wait is treated as zero. A wait after a local-memory access alone is judged against its actual threshold.
- R9: A slot held at a wait, sleep or barrier does not stop other slots from issuing.
- R10: Op 7 (sleep) with argument N makes the slot ineligible for the N cycles that follow its pop.
- R11: Op 8 (barrier) is released in the first cycle in which every active slot of the same workgroup has a barrier at its head. All of those slots then pop together.
- R12: Op 11 (halt) pops and deactivates the slot.
- R13: Per-slot counters are 4 bits. Each counts issued vector-memory ops, issued class-3 ops, and issued scalar loads, and each drops by one on a completion pulse for that slot. Issue of a memory op is held while its counter is at 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| slot_cap | input | SLOT_W+1 | Number of slots that may hold a wavefront |
| launch_valid | input | 1 | Launch a wavefront this cycle |
| launch_slot | input | SLOT_W | Target slot of the launch |
| launch_pc | input | PC_W | Start program counter |
| launch_wg | input | WG_W | Workgroup id of the launched wavefront |
| head_valid | input | NUM_SLOTS | Per-slot instruction buffer head present |
| head_op | input | 4*NUM_SLOTS | Per-slot head op code |
| head_arg | input | 2*CNT_W*NUM_SLOTS | Per-slot head argument |
| vm_done | input | 1 | Vector-memory completion pulse |
| vm_done_id | input | SLOT_W | Slot of the vector-memory completion |
| lgk_done | input | 1 | Local/scalar completion pulse |
| lgk_done_id | input | SLOT_W | Slot of the local/scalar completion |
| lgk_done_scalar | input | 1 | The local/scalar completion belongs to a scalar load |
| head_pop | output | NUM_SLOTS | Per-slot head removal this cycle |
| slot_active | output | NUM_SLOTS | Slot holds a live wavefront |
| iss_valid | output | 4 | Per-class grant |
| iss_slot | output | 4*SLOT_W | Per-class granted slot |
| iss_pc | output | 4*PC_W | Per-class PC of the granted instruction |

## Verification
The round-robin order is swept over a full rotation, with all slots contending in one class at equal priority. The slot sequence and the PC sequence then separate a correct pointer from a fixed-priority one. A pattern with one op per class in the same cycle shows that the classes are independent. A set-priority pattern shows that priority overrides the rotation. Wait patterns hold one slot while another keeps issuing, with completions arriving one at a time. They also contrast a scalar load with a local access under the same nonzero threshold, which tells the scalar-zero rule apart from a plain compare. Sleep, barrier with a late partner, halt, the occupancy cap and counter saturation at 15 each have their own short pattern, whose cycle of release is computed in advance.

// File: rtl/wsched_pkg.sv
package wsched_pkg;

  localparam int NCLS = 4;
  localparam int OP_W = 4;

  localparam int CLS_VALU = 0;
  localparam int CLS_SALU = 1;
  localparam int CLS_VMEM = 2;
  localparam int CLS_LMEM = 3;

  typedef enum logic [OP_W-1:0] {
    OP_VALU  = 4'd0,
    OP_SALU  = 4'd1,
    OP_VMEM  = 4'd2,
    OP_LDS   = 4'd3,
    OP_SMEM  = 4'd4,
    OP_WAIT  = 4'd5,
    OP_NOP   = 4'd6,
    OP_SLEEP = 4'd7,
    OP_BAR   = 4'd8,
    OP_PRIO  = 4'd9,
    OP_VSKIP = 4'd10,
    OP_HALT  = 4'd11
  } op_e;

endpackage

// File: rtl/wsched_arb.sv
module wsched_arb #(
  parameter int N      = 10,
  parameter int PRIO_W = 2,
  parameter int SLOT_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N-1:0]          req,
  input  logic [N*PRIO_W-1:0]   prio,
  output logic                  gnt_valid,
  output logic [SLOT_W-1:0]     gnt_idx
);

  logic [SLOT_W-1:0] ptr_q, ptr_d;
  logic [PRIO_W-1:0] top_p;

  // pass 1: highest priority among requesters; pass 2: rotate from pointer
  always_comb begin
    top_p     = '0;
    gnt_valid = 1'b0;
    gnt_idx   = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && (prio[i*PRIO_W +: PRIO_W] > top_p)) top_p = prio[i*PRIO_W +: PRIO_W];
    end
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = int'(ptr_q) + k;
      if (idx >= N) idx = idx - N;
      if (!gnt_valid && req[idx] && (prio[idx*PRIO_W +: PRIO_W] == top_p)) begin
        gnt_valid = 1'b1;
        gnt_idx   = SLOT_W'(idx);
      end
    end
    ptr_d = (int'(gnt_idx) == N-1) ? '0 : gnt_idx + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ptr_q <= '0;
    else if (gnt_valid) ptr_q <= ptr_d;
  end

  AST_GRANT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> req[gnt_idx]); // R4

endmodule

// File: rtl/wsched_slot.sv
module wsched_slot
  import wsched_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int CNT_W  = 4,
  parameter int PRIO_W = 2,
  parameter int WG_W   = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 launch,
  input  logic [PC_W-1:0]      launch_pc,
  input  logic [WG_W-1:0]      launch_wg,
  input  logic                 head_valid,
  input  logic [OP_W-1:0]      head_op,
  input  logic [2*CNT_W-1:0]   head_arg,
  input  logic                 granted,
  input  logic                 vm_dec,
  input  logic                 lgk_dec,
  input  logic                 lgk_dec_scalar,
  input  logic                 bar_release,
  output logic                 active,
  output logic [NCLS-1:0]      req,
  output logic                 pop,
  output logic                 at_bar,
  output logic [PC_W-1:0]      pc,
  output logic [PRIO_W-1:0]    prio,
  output logic [WG_W-1:0]      wg
);

  localparam int ARG_W = 2*CNT_W;

  logic [CNT_W-1:0] vm_q, lgk_q, sm_q, vm_d, lgk_d, sm_d;
  logic [ARG_W-1:0] slp_q, slp_d;
  logic [PC_W-1:0]  pc_d;
  logic [PRIO_W-1:0] prio_d;
  logic [WG_W-1:0]  wg_d;
  logic             act_d, busy, wait_met, self_pop;
  logic             vm_inc, lgk_inc, sm_inc, sm_dec;
  logic [CNT_W-1:0] lgk_thr;
  op_e              op;

  assign op   = op_e'(head_op);
  assign busy = active && head_valid && (slp_q == '0);

  assign lgk_thr  = (sm_q != '0) ? '0 : head_arg[ARG_W-1:CNT_W];
  assign wait_met = (vm_q <= head_arg[CNT_W-1:0]) && (lgk_q <= lgk_thr);

  always_comb begin
    req      = '0;
    self_pop = 1'b0;
    case (op)
      OP_VALU: req[CLS_VALU] = busy;
      OP_SALU: req[CLS_SALU] = busy;
      OP_VMEM: req[CLS_VMEM] = busy && (vm_q != '1);
      OP_LDS:  req[CLS_LMEM] = busy && (lgk_q != '1);
      OP_SMEM: req[CLS_LMEM] = busy && (lgk_q != '1) && (sm_q != '1);
      OP_WAIT: self_pop = busy && wait_met;
      OP_BAR:  self_pop = busy && bar_release;
      default: self_pop = busy;
    endcase
  end

  assign pop     = granted || self_pop;
  assign at_bar  = busy && (op == OP_BAR);
  assign vm_inc  = granted && (op == OP_VMEM);
  assign lgk_inc = granted && ((op == OP_LDS) || (op == OP_SMEM));
  assign sm_inc  = granted && (op == OP_SMEM);
  assign sm_dec  = lgk_dec && lgk_dec_scalar;

  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] c,
                                            input logic inc, input logic dec);
    if (inc && !dec && (c != '1))      return c + 1'b1;
    else if (dec && !inc && (c != '0)) return c - 1'b1;
    else                               return c;
  endfunction

  always_comb begin
    act_d  = active;
    pc_d   = pc;
    prio_d = prio;
    wg_d   = wg;
    slp_d  = slp_q;
    vm_d   = step(vm_q, vm_inc, vm_dec);
    lgk_d  = step(lgk_q, lgk_inc, lgk_dec);
    sm_d   = step(sm_q, sm_inc, sm_dec);
    if (launch) begin
      act_d  = 1'b1;
      pc_d   = launch_pc;
      wg_d   = launch_wg;
      prio_d = '0;
      slp_d  = '0;
      vm_d   = '0;
      lgk_d  = '0;
      sm_d   = '0;
    end else begin
      if (slp_q != '0) slp_d = slp_q - 1'b1;
      if (pop) begin
        pc_d = pc + 1'b1;
        case (op)
          OP_SLEEP: slp_d  = head_arg;
          OP_PRIO:  prio_d = head_arg[PRIO_W-1:0];
          OP_HALT:  act_d  = 1'b0;
          default:  ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      pc     <= '0;
      prio   <= '0;
      wg     <= '0;
      slp_q  <= '0;
      vm_q   <= '0;
      lgk_q  <= '0;
      sm_q   <= '0;
    end else if (launch || active || vm_dec || lgk_dec) begin
      active <= act_d;
      pc     <= pc_d;
      prio   <= prio_d;
      wg     <= wg_d;
      slp_q  <= slp_d;
      vm_q   <= vm_d;
      lgk_q  <= lgk_d;
      sm_q   <= sm_d;
    end
  end

  AST_HALT_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && (op == OP_HALT) && !launch) |=> !active); // R12
  AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (slp_q != '0) |-> (!pop && (req == '0))); // R10
  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_WAIT && (vm_q > head_arg[CNT_W-1:0])) |-> !pop); // R7
  AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (vm_q == '1 && !vm_dec && !launch) |=> (vm_q == '1)); // R13
  AST_CNT_NO_UNDER: assert property (@(posedge clk) disable iff (!rst_n)
    (lgk_q == '0 && !lgk_inc) |=> (lgk_q == '0)); // R13

endmodule

// File: rtl/wave_issue_sched.sv
module wave_issue_sched
  import wsched_pkg::*;
#(
  parameter int NUM_SLOTS = 10,
  parameter int PC_W      = 16,
  parameter int CNT_W     = 4,
  parameter int PRIO_W    = 2,
  parameter int WG_W      = 2,
  localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int ARG_W    = 2*CNT_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [SLOT_W:0]             slot_cap,
  input  logic                        launch_valid,
  input  logic [SLOT_W-1:0]           launch_slot,
  input  logic [PC_W-1:0]             launch_pc,
  input  logic [WG_W-1:0]             launch_wg,
  input  logic [NUM_SLOTS-1:0]        head_valid,
  input  logic [NUM_SLOTS*OP_W-1:0]   head_op,
  input  logic [NUM_SLOTS*ARG_W-1:0]  head_arg,
  input  logic                        vm_done,
  input  logic [SLOT_W-1:0]           vm_done_id,
  input  logic                        lgk_done,
  input  logic [SLOT_W-1:0]           lgk_done_id,
  input  logic                        lgk_done_scalar,
  output logic [NUM_SLOTS-1:0]        head_pop,
  output logic [NUM_SLOTS-1:0]        slot_active,
  output logic [NCLS-1:0]             iss_valid,
  output logic [NCLS*SLOT_W-1:0]      iss_slot,
  output logic [NCLS*PC_W-1:0]        iss_pc
);

  localparam int NWG = 1 << WG_W;

  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  logic [NCLS-1:0]             s_req [NUM_SLOTS];
  logic [NUM_SLOTS-1:0]        c_req [NCLS];
  logic [PC_W-1:0]             s_pc  [NUM_SLOTS];
  logic [WG_W-1:0]             s_wg  [NUM_SLOTS];
  logic [NUM_SLOTS*PRIO_W-1:0] prio_flat;
  logic [NUM_SLOTS-1:0]        s_bar, s_rel, s_gnt, s_launch, s_vm, s_lgk;
  logic [SLOT_W-1:0]           g_idx [NCLS];
  logic [NWG-1:0]              wg_all;

  genvar gs, gc;
  generate
    for (gs = 0; gs < NUM_SLOTS; gs++) begin : g_slot
      assign s_launch[gs] = launch_valid && (launch_slot == SLOT_W'(gs)) &&
                            !slot_active[gs] && ((SLOT_W+1)'(gs) < slot_cap);
      assign s_vm[gs]  = vm_done  && (vm_done_id  == SLOT_W'(gs));
      assign s_lgk[gs] = lgk_done && (lgk_done_id == SLOT_W'(gs));
      assign s_rel[gs] = wg_all[s_wg[gs]];

      wsched_slot #(.PC_W(PC_W), .CNT_W(CNT_W), .PRIO_W(PRIO_W), .WG_W(WG_W)) i_slot (
        .clk            (clk),
        .rst_n          (rst_ni),
        .launch         (s_launch[gs]),
        .launch_pc      (launch_pc),
        .launch_wg      (launch_wg),
        .head_valid     (head_valid[gs]),
        .head_op        (head_op[gs*OP_W +: OP_W]),
        .head_arg       (head_arg[gs*ARG_W +: ARG_W]),
        .granted        (s_gnt[gs]),
        .vm_dec         (s_vm[gs]),
        .lgk_dec        (s_lgk[gs]),
        .lgk_dec_scalar (lgk_done_scalar),
        .bar_release    (s_rel[gs]),
        .active         (slot_active[gs]),
        .req            (s_req[gs]),
        .pop            (head_pop[gs]),
        .at_bar         (s_bar[gs]),
        .pc             (s_pc[gs]),
        .prio           (prio_flat[gs*PRIO_W +: PRIO_W]),
        .wg             (s_wg[gs])
      );
    end

    for (gc = 0; gc < NCLS; gc++) begin : g_cls
      wsched_arb #(.N(NUM_SLOTS), .PRIO_W(PRIO_W), .SLOT_W(SLOT_W)) i_arb (
        .clk       (clk),
        .rst_n     (rst_ni),
        .req       (c_req[gc]),
        .prio      (prio_flat),
        .gnt_valid (iss_valid[gc]),
        .gnt_idx   (g_idx[gc])
      );
      assign iss_slot[gc*SLOT_W +: SLOT_W] = g_idx[gc];
      assign iss_pc[gc*PC_W +: PC_W]       = s_pc[g_idx[gc]];

      AST_ISSUE_POPS: assert property (@(posedge clk) disable iff (!rst_ni)
        iss_valid[gc] |-> (head_pop[g_idx[gc]] && slot_active[g_idx[gc]])); // R3
      for (genvar gb = gc + 1; gb < NCLS; gb++) begin : g_pair
        AST_DISTINCT_SLOTS: assert property (@(posedge clk) disable iff (!rst_ni)
          (iss_valid[gc] && iss_valid[gb]) |-> (g_idx[gc] != g_idx[gb])); // R3
      end
    end
  endgenerate

  always_comb begin
    for (int c = 0; c < NCLS; c++)
      for (int s = 0; s < NUM_SLOTS; s++)
        c_req[c][s] = s_req[s][c];
    for (int s = 0; s < NUM_SLOTS; s++) begin
      s_gnt[s] = 1'b0;
      for (int c = 0; c < NCLS; c++)
        if (iss_valid[c] && (g_idx[c] == SLOT_W'(s))) s_gnt[s] = 1'b1;
    end
    for (int w = 0; w < NWG; w++) begin
      wg_all[w] = 1'b1;
      for (int s = 0; s < NUM_SLOTS; s++)
        if (slot_active[s] && (s_wg[s] == WG_W'(w)) && !s_bar[s]) wg_all[w] = 1'b0;
    end
  end

endmodule

// File: tb/test_wave_issue_sched.sv
`timescale 1ns/1ps
module test_wave_issue_sched;
  import wsched_pkg::*;

  localparam int N   = 4;
  localparam int SW  = 2;
  localparam int PCW = 16;
  localparam int AW  = 8;
  localparam int DEP = 32;

  logic clk, rst_n;
  logic [SW:0]     slot_cap;
  logic            launch_valid;
  logic [SW-1:0]   launch_slot;
  logic [PCW-1:0]  launch_pc;
  logic [1:0]      launch_wg;
  logic [N-1:0]    head_valid;
  logic [N*4-1:0]  head_op;
  logic [N*AW-1:0] head_arg;
  logic            vm_done, lgk_done, lgk_done_scalar;
  logic [SW-1:0]   vm_done_id, lgk_done_id;
  logic [N-1:0]    head_pop, slot_active;
  logic [3:0]      iss_valid;
  logic [4*SW-1:0] iss_slot;
  logic [4*PCW-1:0] iss_pc;

  wave_issue_sched #(.NUM_SLOTS(N), .PC_W(PCW), .CNT_W(4), .PRIO_W(2), .WG_W(2)) i_wave_issue_sched (
    .clk(clk), .rst_n(rst_n), .slot_cap(slot_cap),
    .launch_valid(launch_valid), .launch_slot(launch_slot), .launch_pc(launch_pc), .launch_wg(launch_wg),
    .head_valid(head_valid), .head_op(head_op), .head_arg(head_arg),
    .vm_done(vm_done), .vm_done_id(vm_done_id),
    .lgk_done(lgk_done), .lgk_done_id(lgk_done_id), .lgk_done_scalar(lgk_done_scalar),
    .head_pop(head_pop), .slot_active(slot_active),
    .iss_valid(iss_valid), .iss_slot(iss_slot), .iss_pc(iss_pc)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // instruction buffer model
  logic [3:0]    prog_op  [N][DEP];
  logic [AW-1:0] prog_arg [N][DEP];
  int            len [N];
  int            ptr [N];

  always_comb begin
    for (int s = 0; s < N; s++) begin
      head_valid[s]         = ptr[s] < len[s];
      head_op[s*4 +: 4]     = prog_op[s][ptr[s] % DEP];
      head_arg[s*AW +: AW]  = prog_arg[s][ptr[s] % DEP];
    end
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < N; s++) ptr[s] <= 0;
    end else begin
      for (int s = 0; s < N; s++) if (head_pop[s]) ptr[s] <= ptr[s] + 1;
    end
  end

  int nvec, nerr;
  bit finished;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [SW-1:0] gslot(input int c);
    return iss_slot[c*SW +: SW];
  endfunction

  function automatic logic [PCW-1:0] gpc(input int c);
    return iss_pc[c*PCW +: PCW];
  endfunction

  task automatic next();
    @(posedge clk);
    #1;
    vm_done = 1'b0; lgk_done = 1'b0; lgk_done_scalar = 1'b0; launch_valid = 1'b0;
    @(negedge clk);
    #1;
  endtask

  task automatic put(input int s, input logic [3:0] op, input logic [AW-1:0] arg);
    prog_op[s][len[s]]  = op;
    prog_arg[s][len[s]] = arg;
    len[s]++;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    slot_cap = 3'd4;
    launch_valid = 1'b0; launch_slot = '0; launch_pc = '0; launch_wg = '0;
    vm_done = 1'b0; vm_done_id = '0; lgk_done = 1'b0; lgk_done_id = '0; lgk_done_scalar = 1'b0;
    for (int s = 0; s < N; s++) len[s] = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
  endtask

  task automatic launch(input int s, input int pc, input int wg);
    launch_valid = 1'b1;
    launch_slot  = SW'(s);
    launch_pc    = PCW'(pc);
    launch_wg    = 2'(wg);
    next();
  endtask

  initial begin
    nvec = 0; nerr = 0; finished = 0;

    // reset state: valid heads present, nothing active
    do_reset();
    put(0, OP_VALU, 0);
    #1;
    chk("R1 active", 32'(slot_active), 0);
    chk("R1 issue", 32'(iss_valid), 0);
    chk("R1 pop", 32'(head_pop), 0);

    // occupancy cap
    do_reset();
    slot_cap = 3'd2;
    launch(2, 0, 0);
    chk("R2 capped slot stays idle", 32'(slot_active[2]), 0);
    launch(1, 0, 0);
    chk("R2 slot under cap active", 32'(slot_active[1]), 1);

    // round robin sweep, equal priority
    do_reset();
    for (int s = 0; s < N; s++) launch(s, 16*s, 0);
    for (int s = 0; s < N; s++) for (int j = 0; j < 3; j++) put(s, OP_VALU, 0);
    #1;
    for (int k = 0; k < 12; k++) begin
      chk("R4 valid", 32'(iss_valid[0]), 1);
      chk("R4 slot", 32'(gslot(0)), 32'(k % 4));
      chk("R3 pc", 32'(gpc(0)), 32'(16*(k % 4) + k / 4));
      next();
    end
    chk("R3 drained", 32'(iss_valid), 0);

    // one op per class in one cycle
    do_reset();
    for (int s = 0; s < N; s++) launch(s, 0, 0);
    put(0, OP_VALU, 0); put(1, OP_SALU, 0); put(2, OP_VMEM, 0); put(3, OP_LDS, 0);
    #1;
    chk("R3 all classes", 32'(iss_valid), 32'hF);
    chk("R3 slots", 32'(iss_slot), 32'({2'd3, 2'd2, 2'd1, 2'd0}));
    next();
    chk("R3 quiet after", 32'(iss_valid), 0);

    // priority over rotation
    do_reset();
    for (int s = 0; s < 3; s++) launch(s, 0, 0);
    put(0, OP_VALU, 0); put(0, OP_VALU, 0);
    put(1, OP_VALU, 0); put(1, OP_VALU, 0);
    put(2, OP_PRIO, 8'd3); put(2, OP_VALU, 0); put(2, OP_VALU, 0);
    #1;
    chk("R6 setprio no grant", 32'(head_pop[2] && iss_valid[0] && gslot(0) == 0), 1);
    chk("R6 other classes idle", 32'(iss_valid[3:1]), 0);
    next();
    chk("R5 high prio wins", 32'(gslot(0)), 2);
    next();
    chk("R5 high prio again", 32'(gslot(0)), 2);
    next();
    chk("R4 rotation resumes", 32'(gslot(0)), 0);

    // wait on vector memory, other slot keeps issuing
    do_reset();
    launch(0, 0, 0); launch(1, 16, 0);
    put(0, OP_VMEM, 0); put(0, OP_VMEM, 0); put(0, OP_WAIT, 8'hF0); put(0, OP_VALU, 0);
    for (int j = 0; j < 6; j++) put(1, OP_VALU, 0);
    #1;
    chk("R13 vmem issue", 32'(iss_valid[2]), 1);
    next(); next();
    chk("R7 wait held", 32'(head_pop[0]), 0);
    chk("R9 other slot issues", 32'(iss_valid[0] && gslot(0) == 1), 1);
    next();
    vm_done = 1'b1; vm_done_id = 0;
    next();
    chk("R7 one outstanding holds", 32'(head_pop[0]), 0);
    vm_done = 1'b1; vm_done_id = 0;
    next();
    chk("R7 wait released", 32'(head_pop[0]), 1);
    next();
    chk("R7 next op issues", 32'(iss_valid[0] && gslot(0) == 0), 1);
    chk("R3 pc after wait", 32'(gpc(0)), 3);

    // scalar-load rule against local-memory access
    do_reset();
    launch(0, 0, 0); launch(1, 0, 0);
    put(0, OP_SMEM, 0); put(0, OP_WAIT, 8'h3F); put(0, OP_VALU, 0);
    put(1, OP_NOP, 0); put(1, OP_LDS, 0); put(1, OP_WAIT, 8'h3F); put(1, OP_VALU, 0);
    #1;
    chk("R3 scalar load class", 32'(iss_valid[3] && gslot(3) == 0), 1);
    next();
    chk("R3 local class", 32'(iss_valid[3] && gslot(3) == 1), 1);
    chk("R8 scalar wait held", 32'(head_pop[0]), 0);
    next();
    chk("R8 local wait met", 32'(head_pop[1]), 1);
    chk("R8 scalar wait still held", 32'(head_pop[0]), 0);
    lgk_done = 1'b1; lgk_done_id = 0; lgk_done_scalar = 1'b1;
    next();
    chk("R8 released after completion", 32'(head_pop[0]), 1);
    next();
    chk("R8 follower issues", 32'(iss_valid[0] && gslot(0) == 0), 1);

    // sleep
    do_reset();
    launch(0, 0, 0);
    put(0, OP_SLEEP, 8'd3); put(0, OP_VALU, 0);
    #1;
    chk("R6 sleep consumed", 32'(head_pop[0] && iss_valid == 0), 1);
    for (int k = 0; k < 3; k++) begin
      next();
      chk("R10 asleep", 32'(iss_valid[0]), 0);
    end
    next();
    chk("R10 wakes", 32'(iss_valid[0] && gpc(0) == 1), 1);

    // barrier with a late partner
    do_reset();
    launch(0, 0, 1); launch(1, 16, 1); launch(2, 32, 0);
    put(0, OP_BAR, 0); put(0, OP_VALU, 0);
    put(1, OP_NOP, 0); put(1, OP_NOP, 0); put(1, OP_BAR, 0); put(1, OP_VALU, 0);
    put(2, OP_BAR, 0); put(2, OP_VALU, 0);
    #1;
    chk("R11 lone group releases", 32'(head_pop[2]), 1);
    chk("R11 partner missing", 32'(head_pop[0]), 0);
    next();
    chk("R11 still waiting", 32'(head_pop[0]), 0);
    chk("R9 other group issues", 32'(iss_valid[0] && gslot(0) == 2), 1);
    next();
    chk("R11 joint release", 32'(head_pop[1:0]), 3);

    // halt
    do_reset();
    launch(3, 0, 0);
    put(3, OP_HALT, 0); put(3, OP_VALU, 0);
    #1;
    chk("R12 halt consumed", 32'(head_pop[3] && iss_valid == 0), 1);
    next();
    chk("R12 retired", 32'(slot_active[3]), 0);
    chk("R12 no issue", 32'(iss_valid), 0);

    // counter saturation
    do_reset();
    launch(0, 0, 0);
    for (int j = 0; j < 16; j++) put(0, OP_VMEM, 0);
    #1;
    for (int k = 0; k < 15; k++) begin
      chk("R13 below limit", 32'(iss_valid[2]), 1);
      next();
    end
    chk("R13 held at 15", 32'(iss_valid[2]), 0);
    vm_done = 1'b1; vm_done_id = 0;
    next();
    chk("R13 resumes", 32'(iss_valid[2] && gpc(2) == 15), 1);

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!finished) begin
      finished = 1;
      nvec++; nerr++;
      $display("FAIL watchdog act=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

endmodule